// File: doc/BRIEF.md
# Privilege-Aware Flags Restore Merger

This unit builds the flags word a processor core takes on when it leaves an interrupt or exception handler. It receives the current 32-bit flags, the flags image taken from the handler's stack, the current privilege level, the operand size of the return and the execution mode. For each flag field it picks either the image or the old value. The rule for each field depends on the mode, on the operand size, and on how the current privilege level compares with the I/O privilege level field held in the current flags. The result is registered.

The block has a single input strobe and no back-pressure. Every cycle in which `in_valid` is high is accepted, and `in_ready` does not exist. One cycle later `out_valid` is high for exactly one cycle, and `out_flags` carries the merged word. `out_flags` keeps that value until the next accepted strobe, so the consumer may sample it at any later time. A strobe on every cycle gives one result per cycle.

Top module: `flags_restore_merge`

## Requirements
- R1: After reset `out_flags` is 0x00000002 and `out_valid` is 0. A strobe on `in_valid` loads `out_flags` and raises `out_valid` at the next clock edge, for one cycle only. Without a strobe, `out_flags` holds its value.
- R2: Real mode (`mode`=0) with a wide operand size (`op_size` 1 = 32-bit, 2 or 3 = 64-bit) yields (image AND 0x257FD5) OR (current AND 0x1A0000), after the R10 fix-up.
- R3: At 16-bit size (`op_size`=0) in real or virtual-8086 mode (`mode`=1), bits 15:0 come from the image and bits 31:16 keep their current values. In virtual-8086 mode the I/O privilege field (bits 13:12) is also kept.
- R4: In virtual-8086 mode at wide size, every bit comes from the image except VM (bit 17), the I/O privilege field (13:12), VIF (bit 19) and VIP (bit 20), which keep their current values.
- R5: In protected (`mode`=2) and long (`mode`=3) modes, CF, PF, AF, ZF, SF, TF, DF, OF and NT (bits 0, 2, 4, 6, 7, 8, 10, 11, 14) always come from the image.
- R6: In protected and long modes, RF, AC and ID (bits 16, 18, 21) come from the image only at wide size. At 16-bit size they keep their current values.
- R7: In protected and long modes, IF (bit 9) comes from the image only when `cpl` is less than or equal to bits 13:12 of the current flags.
- R8: In protected and long modes, the I/O privilege field comes from the image only when `cpl` is 0. VIF and VIP come from the image only when `cpl` is 0 and the size is wide.
- R9: VM (bit 17) keeps its current value in every mode and at every size.
- R10: In every result, bit 1 is 1 and the reserved bits 3, 5, 15 and 31:22 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: merge the inputs on this cycle |
| cur_flags | input | 32 | Flags word before the return |
| img_flags | input | 32 | Flags image taken from the stack |
| cpl | input | 2 | Current privilege level |
| op_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 long |
| out_valid | output | 1 | One-cycle pulse: merged result is ready |
| out_flags | output | 32 | Registered merged flags |

## Verification
A wrong per-field write enable shows up as a single wrong bit in `out_flags`. It appears on the `out_valid` cycle that follows the strobe which uses that field's rule. Each field's rule must therefore be driven with an image whose bits differ from the current flags. A stuck or mistimed output register shows up as a missing or doubled `out_valid` pulse, or as `out_flags` changing during cycles that have no strobe. Errors in the I/O privilege comparison appear only when `cpl` lies on either side of the current IOPL, so the tests cover both sides and the equal case.

// File: rtl/flagmrg_pkg.sv
package flagmrg_pkg;
  localparam int FLAGS_W = 32;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } exec_mode_e;

  localparam int B_CF = 0, B_PF = 2, B_AF = 4, B_ZF = 6, B_SF = 7, B_TF = 8;
  localparam int B_IF = 9, B_DF = 10, B_OF = 11, B_IOPL = 12, B_NT = 14;
  localparam int B_RF = 16, B_VM = 17, B_AC = 18, B_VIF = 19, B_VIP = 20, B_ID = 21;

  localparam logic [FLAGS_W-1:0] ONE = {{(FLAGS_W-1){1'b0}}, 1'b1};
  localparam logic [FLAGS_W-1:0] M_IOPL = (ONE << B_IOPL) | (ONE << (B_IOPL + 1));
  localparam logic [FLAGS_W-1:0] M_ALWAYS =
    (ONE << B_CF) | (ONE << B_PF) | (ONE << B_AF) | (ONE << B_ZF) | (ONE << B_SF) |
    (ONE << B_TF) | (ONE << B_DF) | (ONE << B_OF) | (ONE << B_NT);
  localparam logic [FLAGS_W-1:0] M_WIDE  = (ONE << B_RF) | (ONE << B_AC) | (ONE << B_ID);
  localparam logic [FLAGS_W-1:0] M_VIRT  = (ONE << B_VIF) | (ONE << B_VIP);
  localparam logic [FLAGS_W-1:0] M_IF    = ONE << B_IF;
  localparam logic [FLAGS_W-1:0] M_VM    = ONE << B_VM;
  localparam logic [FLAGS_W-1:0] M_LOW16 = {{(FLAGS_W-16){1'b0}}, 16'hFFFF};
  localparam logic [FLAGS_W-1:0] M_REAL_IMG = 32'h0025_7FD5;
  localparam logic [FLAGS_W-1:0] M_FIXED_ONE = ONE << 1;
  localparam logic [FLAGS_W-1:0] M_DEFINED =
    M_ALWAYS | M_WIDE | M_VIRT | M_IF | M_VM | M_IOPL;

  function automatic logic [FLAGS_W-1:0] fixup(input logic [FLAGS_W-1:0] v);
    return (v & M_DEFINED) | M_FIXED_ONE;
  endfunction
endpackage

// File: rtl/flagmrg_wmask.sv
module flagmrg_wmask
  import flagmrg_pkg::*;
(
  input  exec_mode_e         mode,
  input  logic               wide,
  input  logic [1:0]         cpl,
  input  logic [1:0]         cur_iopl,
  output logic [FLAGS_W-1:0] take_img
);
  logic priv_zero;
  logic if_allowed;

  assign priv_zero  = (cpl == 2'd0);
  assign if_allowed = (cpl <= cur_iopl);

  always_comb begin
    unique case (mode)
      MODE_REAL: take_img = wide ? M_REAL_IMG : M_LOW16;
      MODE_V86:  take_img = wide ? ~(M_VM | M_IOPL | M_VIRT) : (M_LOW16 & ~M_IOPL);
      default: begin
        take_img = M_ALWAYS;
        if (wide)                   take_img = take_img | M_WIDE;
        if (if_allowed)             take_img = take_img | M_IF;
        if (priv_zero)              take_img = take_img | M_IOPL;
        if (priv_zero && wide)      take_img = take_img | M_VIRT;
      end
    endcase
  end
endmodule

// File: rtl/flagmrg_bitmux.sv
module flagmrg_bitmux #(
  parameter int W = 32
) (
  input  logic [W-1:0] sel_b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = sel_b[i] ? b[i] : a[i];
  end
endmodule

// File: rtl/flags_restore_merge.sv
module flags_restore_merge
  import flagmrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        cur_flags,
  input  logic [31:0]        img_flags,
  input  logic [1:0]         cpl,
  input  logic [1:0]         op_size,
  input  logic [1:0]         mode,
  output logic               out_valid,
  output logic [31:0]        out_flags
);
  logic [FLAGS_W-1:0] take_img;
  logic [FLAGS_W-1:0] merged;
  logic               wide;

  assign wide = (op_size != 2'd0);

  flagmrg_wmask u_wmask (
    .mode     (exec_mode_e'(mode)),
    .wide     (wide),
    .cpl      (cpl),
    .cur_iopl (cur_flags[B_IOPL +: 2]),
    .take_img (take_img)
  );

  flagmrg_bitmux #(.W(FLAGS_W)) u_mux (
    .sel_b (take_img),
    .a     (cur_flags),
    .b     (img_flags),
    .y     (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flags <= M_FIXED_ONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_flags <= fixup(merged);
    end
  end
endmodule

// File: rtl/flagmrg_checker.sv
module flagmrg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] cur_flags,
  input logic [1:0]  cpl,
  input logic [1:0]  mode,
  input logic        out_valid,
  input logic [31:0] out_flags
);
  p_pulse_follows_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_without_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_flags));
  p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[1] && !out_flags[3] && !out_flags[5] &&
                   !out_flags[15] && out_flags[31:22] == 10'd0));
  p_vm_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_flags[17] == $past(cur_flags[17]));
  p_if_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && cpl > cur_flags[13:12]) |=> out_flags[9] == $past(cur_flags[9]));
  p_iopl_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && cpl != 2'd0) |=> out_flags[13:12] == $past(cur_flags[13:12]));
endmodule

bind flags_restore_merge flagmrg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .cur_flags (cur_flags),
  .cpl       (cpl),
  .mode      (mode),
  .out_valid (out_valid),
  .out_flags (out_flags)
);

// File: tb/sim_flags_restore_merge.sv
module sim_flags_restore_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] cur_flags = '0;
  logic [31:0] img_flags = '0;
  logic [1:0]  cpl = '0;
  logic [1:0]  op_size = '0;
  logic [1:0]  mode = '0;
  logic        out_valid;
  logic [31:0] out_flags;
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  flags_restore_merge u0 (.*);

  function automatic logic [31:0] model(logic [31:0] c, logic [31:0] g,
                                        logic [1:0] p, logic [1:0] s, logic [1:0] m);
    logic [31:0] r = c;
    logic w = (s != 2'd0);
    if (m == 2'd0) begin
      if (w) r = (g & 32'h0025_7FD5) | (c & 32'h001A_0000);
      else   r[15:0] = g[15:0];
    end else if (m == 2'd1) begin
      if (w) begin
        r = g; r[17] = c[17]; r[20:19] = c[20:19];
      end else r[15:0] = g[15:0];
      r[13:12] = c[13:12];
    end else begin
      foreach (r[b]) if (b inside {0, 2, 4, 6, 7, 8, 10, 11, 14}) r[b] = g[b];
      if (w) begin r[16] = g[16]; r[18] = g[18]; r[21] = g[21]; end
      if (p <= c[13:12]) r[9] = g[9];
      if (p == 2'd0) begin
        r[13:12] = g[13:12];
        if (w) r[20:19] = g[20:19];
      end
    end
    r[1] = 1'b1; r[3] = 1'b0; r[5] = 1'b0; r[15] = 1'b0; r[31:22] = '0;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] c, logic [31:0] g,
                       logic [1:0] p, logic [1:0] s, logic [1:0] m, logic [31:0] exp);
    @(negedge clk);
    cur_flags = c; img_flags = g; cpl = p; op_size = s; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_flags, exp);
  endtask

  task automatic t_reset;
    check("R1 reset flags", out_flags, 32'h0000_0002);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_real32;
    apply("R2 real32 ones", 32'h0, 32'hFFFF_FFFF, 2'd0, 2'd1, 2'd0, 32'h0025_7FD7);
    apply("R2 real64 old", 32'hFFFF_FFFF, 32'h0, 2'd3, 2'd2, 2'd0, 32'h001A_0002);
  endtask

  task automatic t_16bit;
    apply("R3 real16", 32'h0035_0000, 32'hFFFF_7FD5, 2'd0, 2'd0, 2'd0,
          model(32'h0035_0000, 32'hFFFF_7FD5, 2'd0, 2'd0, 2'd0));
    apply("R3 v86 16", 32'h0022_3000, 32'h0015_0FFF, 2'd3, 2'd0, 2'd1,
          model(32'h0022_3000, 32'h0015_0FFF, 2'd3, 2'd0, 2'd1));
  endtask

  task automatic t_v86_wide;
    apply("R4 v86 wide", 32'h001A_3000, 32'h0025_4FD5, 2'd3, 2'd1, 2'd1, 32'h003F_7FD7);
    apply("R4 R9 v86 wide inv", 32'h0005_0002, 32'h003A_3000, 2'd3, 2'd2, 2'd1,
          model(32'h0005_0002, 32'h003A_3000, 2'd3, 2'd2, 2'd1));
  endtask

  task automatic t_prot;
    apply("R5 R6 R8 prot cpl0 wide", 32'h0000_0002, 32'hFFFF_FFFF, 2'd0, 2'd1, 2'd2, 32'h003D_7FD7);
    apply("R6 prot 16 keeps upper", 32'h0025_0000, 32'h0000_4FD5, 2'd0, 2'd0, 2'd2,
          model(32'h0025_0000, 32'h0000_4FD5, 2'd0, 2'd0, 2'd2));
    apply("R8 long cpl3 keeps iopl", 32'h0018_3000, 32'h0000_0200, 2'd3, 2'd2, 2'd3,
          model(32'h0018_3000, 32'h0000_0200, 2'd3, 2'd2, 2'd3));
  endtask

  task automatic t_if_gate;
    apply("R7 cpl>iopl keeps IF", 32'h0000_1202, 32'h0000_0000, 2'd2, 2'd1, 2'd2, 32'h0000_1202);
    apply("R7 cpl=iopl takes IF", 32'h0000_2002, 32'h0000_0200, 2'd2, 2'd1, 2'd3, 32'h0000_2202);
    apply("R7 cpl<iopl takes IF", 32'h0000_3202, 32'h0000_0000, 2'd1, 2'd1, 2'd2, 32'h0000_3002);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    apply("R1 load", 32'h0, 32'h0000_08C1, 2'd0, 2'd1, 2'd2, 32'h0000_08C3);
    prev = out_flags;
    @(negedge clk);
    cur_flags = 32'hFFFF_FFFF; img_flags = 32'hFFFF_FFFF; mode = 2'd2;
    @(negedge clk);
    check("R1 single pulse", {31'd0, out_valid}, 32'd0);
    check("R1 hold", out_flags, prev);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    cur_flags = 32'h0; img_flags = 32'h0000_0001; cpl = 0; op_size = 1; mode = 2; in_valid = 1;
    @(negedge clk);
    check("R1 b2b first", out_flags, 32'h0000_0003);
    img_flags = 32'h0000_0004;
    @(negedge clk);
    in_valid = 0;
    check("R1 b2b second", out_flags, 32'h0000_0006);
    check("R1 b2b valid", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_real32();
    t_16bit();
    t_v86_wide();
    t_prot();
    t_if_gate();
    t_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule